// File: doc/BRIEF.md
# Strobe-Ordered DRAM Cycle Classifier

This block is the control front end on the device side of an asynchronous-strobe DRAM. The row strobe, column strobe, write strobe, output-enable strobe and the multiplexed address pins are all sampled on a fast system clock, so every strobe edge is seen as a change between two clock samples. On each row-strobe fall, and on the column-strobe and write-strobe edges that follow it, the block decides which kind of cycle is under way. It then emits one-cycle pulses that latch a row, latch a column, start a read and commit a write, together with a pulse that selects the internal refresh row.

A 12-bit internal counter supplies the row for refreshes that take their row from inside the device. There are three such refreshes: a column-strobe-first refresh, a hidden refresh that follows a read while its data is still held, and a test-entry refresh, in which the write strobe is low and an address key is present. The counter steps once per internal refresh and wraps around at the end of its range. A mode flag records test entry. Any later refresh clears it, except a further test entry.

Read data becomes valid a fixed number of clocks after the column strobe falls. After that it stays driven, gated by output enable, until both the row and column strobes are high.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, `cyc_kind` is 0 (idle), every pulse output is 0, `test_mode`, `dq_drive` and `indet` are 0, and the first internal refresh uses row 0.
- R2: When the row strobe falls with the column strobe high, `row_latch` pulses for one cycle, `row_addr` takes the address pins and `cyc_kind` becomes 1 (row open). Outputs change on the clock after the edge is first sampled.
- R3: When the column strobe falls with the write strobe high in an open row, `col_latch` and `rd_start` pulse, `col_addr` takes the low 10 address bits and `cyc_kind` becomes 2 (read). `dq_drive` rises ACC_CYC clocks after `rd_start`, provided output enable is low.
- R4: When the column strobe falls with the write strobe already low, `cyc_kind` becomes 3 (early write) and `wr_commit` pulses. `dq_drive` stays 0 for as long as the cycle lasts.
- R5: When the write strobe falls during a read after the data has become valid, `cyc_kind` becomes 4 (read-write) and `wr_commit` pulses. `dq_drive` stays asserted.
- R6: When the write strobe falls during a read before the data is valid, `indet` is set, `cyc_kind` becomes 4 and `wr_commit` pulses, and `dq_drive` stays 0. `indet` clears on the next column-strobe fall or row-strobe fall.
- R7: Every further column-strobe fall while the row strobe stays low starts a new page access, with a fresh `col_latch` and a new `col_addr`.
- R8: When the row strobe rises with no column-strobe fall since the row opened, `cyc_kind` becomes 5 (row-only refresh), `row_addr` keeps the row, and `test_mode` clears.
- R9: When the row strobe falls with the column strobe low, no read data held, and no test key, `cyc_kind` becomes 6 (internal refresh). `ref_sel` pulses, `ref_row` shows the counter, the counter steps, `row_latch` stays 0, and `test_mode` clears.
- R10: Consecutive internal refreshes report consecutive `ref_row` values, and 4095 is followed by 0.
- R11: When the row strobe falls with the column strobe still low and read data still held, `cyc_kind` becomes 7 (hidden refresh). `ref_sel` pulses, the counter steps, `dq_drive` stays asserted, and `test_mode` clears.
- R12: When the row strobe falls with the column strobe low, the write strobe low and address bits [9:0] all ones, `cyc_kind` becomes 8 (test entry), `test_mode` is set and the counter steps. With any other key, the cycle is an ordinary internal refresh (R9).
- R13: `dq_drive` is 0 whenever output enable is high. Held data is dropped once both the row and column strobes are sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 12 | Multiplexed row/column address pins |
| cyc_kind | output | 4 | Current cycle classification |
| row_latch | output | 1 | One-cycle pulse: external row captured |
| col_latch | output | 1 | One-cycle pulse: column captured |
| rd_start | output | 1 | One-cycle pulse: read access begins |
| wr_commit | output | 1 | One-cycle pulse: write into the cells |
| ref_sel | output | 1 | One-cycle pulse: internal-counter refresh |
| row_addr | output | 12 | Latched external row |
| col_addr | output | 10 | Latched column |
| ref_row | output | 12 | Row used by the latest internal refresh |
| dq_drive | output | 1 | Data pins driven with valid read data |
| indet | output | 1 | Read-write with undefined output data |
| test_mode | output | 1 | Compressed-test mode active |

## Verification
On every cycle, the assertions check several properties:
- a row-strobe fall with the column strobe high always yields a row latch;
- a column-first fall always yields a refresh pulse and never a row latch;
- successive refresh rows differ by one, modulo the counter range;
- no data is driven during an early write or an indeterminate read-write, or after both strobes have been high;
- test mode only ever rises on a test-entry cycle.

Only the bench's scenarios can show the remaining behaviour. That covers the exact access latency, page-mode column updates, held data surviving a hidden refresh, the key compare for test entry, the exits from test mode, and the full 4096-step wrap. For these, a behavioural reference model is compared against the design on every clock.

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int AW      = 12,
  parameter int CW      = 10,
  parameter int ACC_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic [3:0]    cyc_kind,
  output logic          row_latch,
  output logic          col_latch,
  output logic          rd_start,
  output logic          wr_commit,
  output logic          ref_sel,
  output logic [AW-1:0] row_addr,
  output logic [CW-1:0] col_addr,
  output logic [AW-1:0] ref_row,
  output logic          dq_drive,
  output logic          indet,
  output logic          test_mode
);
  localparam int ACW = $clog2(ACC_CYC + 1);
  localparam logic [ACW-1:0] ACC_LAST = ACW'(ACC_CYC - 1);
  localparam logic [CW-1:0] TEST_KEY = '1;

  localparam logic [3:0] K_IDLE = 4'd0, K_OPEN = 4'd1, K_READ = 4'd2,
                         K_EWR = 4'd3, K_RWR = 4'd4, K_RONLY = 4'd5,
                         K_CBR = 4'd6, K_HIDDEN = 4'd7, K_TEST = 4'd8;

  logic p_ras, p_cas, p_we;
  logic row_open, cas_seen, rd_pend, dvalid;
  logic [ACW-1:0] acc_cnt;
  logic [AW-1:0] ref_cnt;

  wire ras_fall = p_ras & ~ras_n;
  wire ras_rise = ~p_ras & ras_n;
  wire cas_fall = p_cas & ~cas_n;
  wire we_fall  = p_we & ~we_n;
  wire key_ok   = (addr[CW-1:0] == TEST_KEY);

  assign dq_drive = dvalid & ~oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_ras <= 1'b1; p_cas <= 1'b1; p_we <= 1'b1;
      row_open <= 1'b0; cas_seen <= 1'b0;
      rd_pend <= 1'b0; dvalid <= 1'b0; acc_cnt <= '0;
      ref_cnt <= '0; ref_row <= '0;
      row_addr <= '0; col_addr <= '0;
      cyc_kind <= K_IDLE;
      row_latch <= 1'b0; col_latch <= 1'b0; rd_start <= 1'b0;
      wr_commit <= 1'b0; ref_sel <= 1'b0;
      indet <= 1'b0; test_mode <= 1'b0;
    end else begin
      p_ras <= ras_n; p_cas <= cas_n; p_we <= we_n;
      row_latch <= 1'b0; col_latch <= 1'b0; rd_start <= 1'b0;
      wr_commit <= 1'b0; ref_sel <= 1'b0;

      if (rd_pend) begin
        if (acc_cnt == ACC_LAST) begin
          dvalid  <= 1'b1;
          rd_pend <= 1'b0;
        end else begin
          acc_cnt <= acc_cnt + 1'b1;
        end
      end

      if (ras_fall) begin
        indet <= 1'b0;
        if (cas_n) begin
          row_open  <= 1'b1;
          cas_seen  <= 1'b0;
          row_addr  <= addr;
          row_latch <= 1'b1;
          cyc_kind  <= K_OPEN;
          dvalid    <= 1'b0;
          rd_pend   <= 1'b0;
        end else begin
          row_open <= 1'b0;
          ref_sel  <= 1'b1;
          ref_row  <= ref_cnt;
          ref_cnt  <= ref_cnt + 1'b1;
          if (dvalid) begin
            cyc_kind  <= K_HIDDEN;
            test_mode <= 1'b0;
          end else if (!we_n && key_ok) begin
            cyc_kind  <= K_TEST;
            test_mode <= 1'b1;
          end else begin
            cyc_kind  <= K_CBR;
            test_mode <= 1'b0;
          end
        end
      end else if (ras_rise) begin
        row_open <= 1'b0;
        if (row_open && !cas_seen) begin
          cyc_kind  <= K_RONLY;
          test_mode <= 1'b0;
        end
      end else if (cas_fall && row_open) begin
        cas_seen  <= 1'b1;
        col_addr  <= addr[CW-1:0];
        col_latch <= 1'b1;
        indet     <= 1'b0;
        dvalid    <= 1'b0;
        if (!we_n) begin
          cyc_kind  <= K_EWR;
          wr_commit <= 1'b1;
          rd_pend   <= 1'b0;
        end else begin
          cyc_kind <= K_READ;
          rd_start <= 1'b1;
          rd_pend  <= 1'b1;
          acc_cnt  <= '0;
        end
      end else if (we_fall && row_open && !cas_n && cyc_kind == K_READ) begin
        cyc_kind  <= K_RWR;
        wr_commit <= 1'b1;
        if (!dvalid) begin
          indet   <= 1'b1;
          rd_pend <= 1'b0;
          dvalid  <= 1'b0;
        end
      end

      if (ras_n && cas_n) begin
        dvalid  <= 1'b0;
        rd_pend <= 1'b0;
      end
    end
  end

  logic [AW-1:0] chk_last_ref;
  logic          chk_ref_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_last_ref <= '0;
      chk_ref_seen <= 1'b0;
    end else if (ref_sel) begin
      chk_last_ref <= ref_row;
      chk_ref_seen <= 1'b1;
    end
  end

  // R2
  row_strobe_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ras_n) && !ras_n && cas_n) |=> row_latch);
  // R9
  cbr_refresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ras_n) && !ras_n && !cas_n) |=> (ref_sel && !row_latch));
  // R10
  ref_row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel && chk_ref_seen) |-> (ref_row == chk_last_ref + 1'b1));
  // R4
  early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == K_EWR) |-> !dq_drive);
  // R6
  indet_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    indet |-> !dq_drive);
  // R13
  data_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n && $past(ras_n) && $past(cas_n)) |-> !dq_drive);
  // R12
  test_entry_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> (cyc_kind == K_TEST));
  // R3
  read_has_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> col_latch);
endmodule

// File: tb/tb_dram_cycle_decoder.sv
module tb_dram_cycle_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, CW = 10, ACC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [3:0] cyc_kind;
  logic row_latch, col_latch, rd_start, wr_commit, ref_sel, dq_drive, indet, test_mode;
  logic [AW-1:0] row_addr, ref_row;
  logic [CW-1:0] col_addr;

  dram_cycle_decoder #(.AW(AW), .CW(CW), .ACC_CYC(ACC)) dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .cyc_kind(cyc_kind), .row_latch(row_latch),
    .col_latch(col_latch), .rd_start(rd_start), .wr_commit(wr_commit),
    .ref_sel(ref_sel), .row_addr(row_addr), .col_addr(col_addr),
    .ref_row(ref_row), .dq_drive(dq_drive), .indet(indet), .test_mode(test_mode));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nfail = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit mpr = 1, mpc = 1, mpw = 1, m_open = 0, m_seen = 0, m_valid = 0, m_indet = 0, m_test = 0;
  bit m_rl = 0, m_cl = 0, m_rd = 0, m_wr = 0, m_rs = 0;
  int m_kind = 0, m_row = 0, m_col = 0, m_cnt = 0, m_ref = 0, m_wait = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mpr = 1; mpc = 1; mpw = 1; m_open = 0; m_seen = 0; m_valid = 0; m_indet = 0;
      m_test = 0; m_rl = 0; m_cl = 0; m_rd = 0; m_wr = 0; m_rs = 0;
      m_kind = 0; m_row = 0; m_col = 0; m_cnt = 0; m_ref = 0; m_wait = 0;
    end else begin
      bit o_valid, o_open;
      int o_wait;
      o_valid = m_valid; o_open = m_open; o_wait = m_wait;
      m_rl = 0; m_cl = 0; m_rd = 0; m_wr = 0; m_rs = 0;
      if (m_wait > 0) begin
        m_wait--;
        if (m_wait == 0) m_valid = 1;
      end
      if (mpr && !ras_n) begin
        m_indet = 0;
        if (cas_n) begin
          m_open = 1; m_seen = 0; m_row = addr; m_rl = 1; m_kind = 1;
          m_valid = 0; m_wait = 0;
        end else begin
          m_open = 0; m_rs = 1; m_ref = m_cnt; m_cnt = (m_cnt + 1) % 4096;
          if (o_valid) begin m_kind = 7; m_test = 0; end
          else if (!we_n && addr[CW-1:0] == 10'h3FF) begin m_kind = 8; m_test = 1; end
          else begin m_kind = 6; m_test = 0; end
        end
      end else if (!mpr && ras_n) begin
        m_open = 0;
        if (o_open && !m_seen) begin m_kind = 5; m_test = 0; end
      end else if (mpc && !cas_n && o_open) begin
        m_seen = 1; m_col = addr[CW-1:0]; m_cl = 1; m_indet = 0; m_valid = 0;
        if (!we_n) begin m_kind = 3; m_wr = 1; m_wait = 0; end
        else begin m_kind = 2; m_rd = 1; m_wait = ACC; end
      end else if (mpw && !we_n && o_open && !cas_n && m_kind == 2) begin
        m_kind = 4; m_wr = 1;
        if (!o_valid) begin m_indet = 1; m_wait = 0; m_valid = 0; end
      end
      if (ras_n && cas_n) begin m_valid = 0; m_wait = 0; end
      mpr = ras_n; mpc = cas_n; mpw = we_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 cyc_kind", cyc_kind, m_kind);
      chk("R2 row_latch", row_latch, m_rl);
      chk("R2 row_addr", row_addr, m_row);
      chk("R7 col_latch", col_latch, m_cl);
      chk("R7 col_addr", col_addr, m_col);
      chk("R3 rd_start", rd_start, m_rd);
      chk("R4 wr_commit", wr_commit, m_wr);
      chk("R9 ref_sel", ref_sel, m_rs);
      chk("R10 ref_row", ref_row, m_ref);
      chk("R13 dq_drive", dq_drive, m_valid && !oe_n);
      chk("R6 indet", indet, m_indet);
      chk("R12 test_mode", test_mode, m_test);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic step(input bit r, input bit c, input bit w, input bit o, input int a);
    @(posedge clk); #2;
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = AW'(a);
  endtask

  task automatic look();
    @(posedge clk); @(negedge clk);
  endtask

  int exp_ref = 0;

  task automatic cbr();
    step(1, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    look();
    chk("R10 wrap sequence", ref_row, exp_ref % 4096);
    exp_ref++;
    step(1, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset kind", cyc_kind, 0);
    chk("R1 reset pulses", {row_latch, col_latch, rd_start, wr_commit, ref_sel}, 0);
    chk("R1 reset flags", {test_mode, dq_drive, indet}, 0);

    // read with page access and read-write
    step(0, 1, 1, 0, 12'h5A3); look();
    chk("R2 row_latch", row_latch, 1);
    chk("R2 row_addr", row_addr, 12'h5A3);
    chk("R2 kind open", cyc_kind, 1);
    step(0, 0, 1, 0, 12'h2C4); look();
    chk("R3 read pulses", {col_latch, rd_start}, 2'b11);
    chk("R3 col_addr", col_addr, 10'h2C4);
    chk("R3 not yet valid", dq_drive, 0);
    repeat (ACC) @(negedge clk);
    chk("R3 data valid", dq_drive, 1);
    step(0, 1, 1, 0, 0);
    step(0, 0, 1, 0, 12'h011); look();
    chk("R7 page col_latch", col_latch, 1);
    chk("R7 page col_addr", col_addr, 10'h011);
    repeat (ACC) @(negedge clk);
    step(0, 0, 1, 1, 12'h011); @(negedge clk);
    chk("R13 oe high", dq_drive, 0);
    step(0, 0, 1, 0, 12'h011); @(negedge clk);
    chk("R13 oe low again", dq_drive, 1);
    step(0, 0, 0, 0, 12'h011); look();
    chk("R5 read-write kind", cyc_kind, 4);
    chk("R5 write pulse", wr_commit, 1);
    chk("R5 data kept", dq_drive, 1);
    step(1, 1, 1, 0, 0); look();
    chk("R13 released", dq_drive, 0);

    // early write
    step(0, 1, 1, 0, 12'h0F0);
    step(0, 0, 0, 0, 12'h155); look();
    chk("R4 early write kind", cyc_kind, 3);
    chk("R4 write pulse", wr_commit, 1);
    repeat (4) @(negedge clk);
    chk("R4 no drive", dq_drive, 0);
    step(1, 1, 1, 0, 0);

    // indeterminate
    step(0, 1, 1, 0, 12'h100);
    step(0, 0, 1, 0, 12'h0AA);
    step(0, 0, 0, 0, 12'h0AA); look();
    chk("R6 indet set", indet, 1);
    chk("R6 kind", cyc_kind, 4);
    repeat (4) @(negedge clk);
    chk("R6 no drive", dq_drive, 0);
    step(1, 1, 1, 0, 0);
    step(0, 1, 1, 0, 12'h200); look();
    chk("R6 cleared by row fall", indet, 0);
    step(1, 1, 1, 0, 0); look();
    chk("R8 row-only after page", cyc_kind, 5);

    // row-only refresh
    step(0, 1, 1, 0, 12'h777);
    step(1, 1, 1, 0, 0); look();
    chk("R8 row-only kind", cyc_kind, 5);
    chk("R8 row kept", row_addr, 12'h777);

    // internal refreshes
    step(1, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0); look();
    chk("R9 cbr kind", cyc_kind, 6);
    chk("R9 ref pulse", ref_sel, 1);
    chk("R9 no row latch", row_latch, 0);
    chk("R1 first row zero", ref_row, 0);
    step(1, 1, 1, 0, 0);
    step(1, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0); look();
    chk("R10 second row", ref_row, 1);
    step(1, 1, 1, 0, 0);

    // test entry, bad key, exit via row-only
    step(1, 0, 0, 0, 12'h3FF);
    step(0, 0, 0, 0, 12'h3FF); look();
    chk("R12 test kind", cyc_kind, 8);
    chk("R12 test set", test_mode, 1);
    chk("R12 counter stepped", ref_row, 2);
    step(1, 1, 1, 0, 0);
    step(1, 0, 0, 0, 12'h3FE);
    step(0, 0, 0, 0, 12'h3FE); look();
    chk("R12 bad key is cbr", cyc_kind, 6);
    chk("R9 cbr clears test", test_mode, 0);
    step(1, 1, 1, 0, 0);
    step(1, 0, 0, 0, 12'hFFF);
    step(0, 0, 0, 0, 12'hFFF); look();
    chk("R12 re-entry", test_mode, 1);
    step(1, 1, 1, 0, 0);
    step(0, 1, 1, 0, 12'h123);
    step(1, 1, 1, 0, 0); look();
    chk("R8 row-only exits test", test_mode, 0);

    // hidden refresh
    step(0, 1, 1, 0, 12'h321);
    step(0, 0, 1, 0, 12'h0C3);
    repeat (ACC + 1) @(posedge clk);
    step(1, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0); look();
    chk("R11 hidden kind", cyc_kind, 7);
    chk("R11 ref pulse", ref_sel, 1);
    chk("R11 data held", dq_drive, 1);
    chk("R11 row", ref_row, 5);
    step(1, 0, 1, 0, 0);
    step(1, 1, 1, 0, 0);

    exp_ref = 6;
    for (int i = 0; i < 4100; i++) cbr();

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule